// File: doc/BRIEF.md
# Half to Single Precision Float Widener

This block widens a 16-bit IEEE 754 half-precision value into the 32-bit single-precision value that represents exactly the same number. Every half value is exactly representable in single precision, so no rounding is involved. The block re-biases the exponent and moves the fraction into the upper fraction bits. Subnormal halves become normal singles after a leading-one search. Infinities keep their class. NaNs come out quiet and keep their payload.

Input and output are valid/ready streams. A word moves on either side only on a clock edge where valid and ready are both high. An accepted half appears as a registered single on the next cycle. The output word and its valid stay frozen while the consumer holds ready low. While a result is waiting and the consumer is not ready, the block holds its input ready low. When the consumer takes the result, the same cycle can accept a new input. At full throughput the block converts one value per clock.

Top module: `half_to_single_cvt`

## Requirements
- R1: Bit 31 of the output always equals bit 15 of the accepted input.
- R2: For an input exponent field (bits 14:10) between 1 and 30, the output exponent (bits 30:23) is that field plus 112, and output bits 22:13 equal input bits 9:0, with bits 12:0 zero.
- R3: An input with exponent field 0 and fraction 0 gives an output of zero with the input's sign.
- R4: An input with exponent field 0 and fraction f ≠ 0, where the highest set bit of f is at position p (0..9), gives output exponent 103+p. The output fraction is f shifted left by 10−p with bit 10 dropped, placed in bits 22:13.
- R5: An input with exponent field 31 and fraction 0 gives an infinity: exponent 255, fraction 0.
- R6: An input with exponent field 31 and fraction f ≠ 0 gives a quiet NaN: exponent 255, bit 22 set, bits 21:13 equal to f bits 8:0, bits 12:0 zero.
- R7: An input accepted on a clock edge gives out_valid high with its result after that edge.
- R8: While out_valid is high and out_ready is low, out_valid and out_single stay unchanged on the next edge.
- R9: in_ready is low exactly when out_valid is high and out_ready is low.
- R10: Reset (rst_n low, asynchronous) clears out_valid and drives out_single to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input half value is valid |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_half | input | 16 | Half-precision input word |
| out_valid | output | 1 | Output single value is valid |
| out_ready | input | 1 | Consumer accepts the output this cycle |
| out_single | output | 32 | Single-precision output word |

## Verification
All 65536 half encodings are streamed back-to-back and compared with a bench model. This covers every class and every subnormal leading-one position. A directed list runs under random back-pressure and input gaps: both signed zeros, the smallest and largest normals, subnormals with the leading one at bit 0, bit 9 and in between, both infinities, and NaNs with and without the top payload bit. Each of these patterns exercises one of the classification branches. Stalls check that a held result is neither lost, repeated nor altered. A reset asserted while a result is stalled checks that the output register clears.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;
  localparam int H_EXP_W  = 5;
  localparam int H_FRAC_W = 10;
  localparam int S_EXP_W  = 8;
  localparam int S_FRAC_W = 23;
  localparam int H_W      = 1 + H_EXP_W + H_FRAC_W;
  localparam int S_W      = 1 + S_EXP_W + S_FRAC_W;
  localparam int H_BIAS   = (1 << (H_EXP_W - 1)) - 1;
  localparam int S_BIAS   = (1 << (S_EXP_W - 1)) - 1;
  localparam int BIAS_GAP = S_BIAS - H_BIAS;
  localparam int FRAC_GAP = S_FRAC_W - H_FRAC_W;
  localparam int POS_W    = $clog2(H_FRAC_W);

  typedef struct packed {
    logic                sign;
    logic [H_EXP_W-1:0]  exp;
    logic [H_FRAC_W-1:0] frac;
  } half_t;

  typedef struct packed {
    logic                sign;
    logic [S_EXP_W-1:0]  exp;
    logic [S_FRAC_W-1:0] frac;
  } single_t;
endpackage

// File: rtl/hcvt_lead_one.sv
module hcvt_lead_one #(
  parameter int W = 10,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          any
);
  always_comb begin
    pos = '0;
    any = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos = PW'(i);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    if (any && !$isunknown(vec))
      AST_LEAD_IS_TOP: assert ((vec >> pos) == W'(1)); // R4
  end
endmodule

// File: rtl/hcvt_unpack.sv
module hcvt_unpack
  import hcvt_pkg::*;
(
  input  half_t   h,
  output single_t s
);
  localparam int SHW = POS_W + 1;
  localparam int SUB_EXP_BASE = BIAS_GAP - H_FRAC_W + 1;

  logic [POS_W-1:0]  lead_pos;
  logic              lead_any;
  logic [SHW-1:0]    shamt;
  logic [H_FRAC_W:0] norm;
  logic              exp_max, exp_zero, frac_nz;

  hcvt_lead_one #(.W(H_FRAC_W)) lead_i (
    .vec (h.frac),
    .pos (lead_pos),
    .any (lead_any)
  );

  assign exp_max  = &h.exp;
  assign exp_zero = ~|h.exp;
  assign frac_nz  = lead_any;
  assign shamt    = SHW'(H_FRAC_W) - {1'b0, lead_pos};
  assign norm     = {1'b0, h.frac} << shamt;

  always_comb begin
    s.sign = h.sign;
    if (exp_max) begin
      s.exp  = '1;
      s.frac = frac_nz ? {1'b1, h.frac[H_FRAC_W-2:0], {FRAC_GAP{1'b0}}} : '0;
    end else if (exp_zero) begin
      if (frac_nz) begin
        s.exp  = S_EXP_W'(SUB_EXP_BASE) + S_EXP_W'(lead_pos);
        s.frac = {norm[H_FRAC_W-1:0], {FRAC_GAP{1'b0}}};
      end else begin
        s.exp  = '0;
        s.frac = '0;
      end
    end else begin
      s.exp  = S_EXP_W'(h.exp) + S_EXP_W'(BIAS_GAP);
      s.frac = {h.frac, {FRAC_GAP{1'b0}}};
    end
  end

  always_comb begin
    if (!$isunknown(h)) begin
      if (exp_max && |h.frac)
        AST_NAN_QUIET: assert (&s.exp && s.frac[S_FRAC_W-1]); // R6
      if (exp_max && ~|h.frac)
        AST_INF_CLEAN: assert (&s.exp && ~|s.frac); // R5
      if (exp_zero && |h.frac)
        AST_SUB_RANGE: assert (s.exp >= S_EXP_W'(SUB_EXP_BASE) &&
                               s.exp <  S_EXP_W'(SUB_EXP_BASE + H_FRAC_W)); // R4
      if (exp_zero && ~|h.frac)
        AST_ZERO_SIGNED: assert (s[S_W-2:0] == '0); // R3
    end
  end
endmodule

// File: rtl/hcvt_out_stage.sv
module hcvt_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      q         <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(q)); // R8
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && q == $past(d)); // R7
  AST_READY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9
endmodule

// File: rtl/half_to_single_cvt.sv
module half_to_single_cvt
  import hcvt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [H_W-1:0] in_half,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [S_W-1:0] out_single
);
  half_t   h_in;
  single_t s_wide;

  assign h_in = half_t'(in_half);

  hcvt_unpack unpack_i (
    .h (h_in),
    .s (s_wide)
  );

  hcvt_out_stage #(.W(S_W)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (s_wide),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (out_single)
  );

  AST_SIGN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_single[S_W-1] == $past(in_half[H_W-1])); // R1
  AST_NORMAL_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && |in_half[H_W-2:H_FRAC_W] && !(&in_half[H_W-2:H_FRAC_W])
    |=> out_single[S_W-2:S_FRAC_W] ==
        S_EXP_W'($past(in_half[H_W-2:H_FRAC_W])) + S_EXP_W'(BIAS_GAP)); // R2
endmodule

// File: tb/half_to_single_cvt_tb_top.sv
module half_to_single_cvt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_half = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_single;

  always #5 clk = ~clk;

  half_to_single_cvt dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_half    (in_half),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_single (out_single)
  );

  logic [15:0] sb_q[$];
  int  n_chk = 0;
  int  n_bad = 0;
  bit  run = 1'b0;
  bit  done = 1'b0;
  int  ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] ref_cvt(input logic [15:0] h);
    logic       sg;
    logic [4:0] e;
    logic [9:0] f;
    logic [10:0] m;
    int k;
    sg = h[15]; e = h[14:10]; f = h[9:0];
    if (e == 5'd31) begin
      if (f == 0) return {sg, 8'hFF, 23'd0};
      return {sg, 8'hFF, 1'b1, f[8:0], 13'd0};
    end
    if (e == 5'd0) begin
      if (f == 0) return {sg, 31'd0};
      m = {1'b0, f};
      k = 0;
      while (!m[10]) begin m = m << 1; k++; end
      return {sg, 8'(113 - k), m[9:0], 13'd0};
    end
    return {sg, 8'({3'd0, e} + 8'd112), f, 13'd0};
  endfunction

  function automatic string tag_of(input logic [15:0] h);
    if (h[14:10] == 5'd31) return (h[9:0] == 0) ? "R5" : "R6";
    if (h[14:10] == 5'd0)  return (h[9:0] == 0) ? "R3" : "R4";
    return "R2";
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] v);
    in_valid = 1'b1;
    in_half  = v;
    forever begin
      #2;
      if (in_ready) begin
        sb_q.push_back(v);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // consumer ready driver
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = lfsr[0] | lfsr[3];
        default: out_ready = 1'b0;
      endcase
    end
  end

  // monitor / scoreboard
  initial begin
    bit          hold_pend = 1'b0;
    bit          prev_acc = 1'b0;
    logic [31:0] held = '0;
    logic [15:0] src;
    logic [31:0] exp;
    forever begin
      @(negedge clk);
      #2;
      if (!run) begin
        hold_pend = 1'b0;
        prev_acc  = 1'b0;
        continue;
      end
      if (hold_pend)
        check(out_valid && out_single == held, "R8 held output", out_single, held);
      if (prev_acc)
        check(out_valid, "R7 valid after accept", {31'd0, out_valid}, 32'd1);
      check(in_ready == (!out_valid || out_ready), "R9 input ready",
            {31'd0, in_ready}, {31'd0, (!out_valid || out_ready)});
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7 unexpected output", out_single, 32'hx);
        end else begin
          src = sb_q.pop_front();
          exp = ref_cvt(src);
          check(out_single == exp, tag_of(src), out_single, exp);
          check(out_single[31] == src[15], "R1 sign", {31'd0, out_single[31]},
                {31'd0, src[15]});
        end
      end
      hold_pend = out_valid && !out_ready;
      held      = out_single;
      prev_acc  = in_valid && in_ready;
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  logic [15:0] dir_list [16] = '{
    16'h0000, 16'h8000, 16'h3C00, 16'hC000, 16'h7BFF, 16'h0400, 16'h0001, 16'h0200,
    16'h03FF, 16'h8155, 16'h7C00, 16'hFC00, 16'h7C01, 16'h7E00, 16'hFDFF, 16'h7FFF
  };

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(!out_valid && out_single == 32'd0, "R10 reset state", out_single, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run   = 1'b1;
    @(negedge clk);

    // directed classes under back-pressure and gaps
    ready_mode = 1;
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 16; i++) begin
        send(dir_list[i]);
        if (((i + r) % 3) == 0) idle(1);
      end
    end
    idle(1);
    while (sb_q.size() != 0) @(negedge clk);

    // every encoding at full rate
    ready_mode = 0;
    @(negedge clk);
    for (int i = 0; i < 65536; i++) send(16'(i));
    idle(1);
    while (sb_q.size() != 0) @(negedge clk);

    // stall a result, then reset over it
    ready_mode = 2;
    @(negedge clk);
    send(16'h3C00);
    idle(4);
    run = 1'b0;
    rst_n = 1'b0;
    #2;
    check(!out_valid && out_single == 32'd0, "R10 reset clears held", out_single, 32'd0);
    sb_q.delete();
    @(negedge clk);
    rst_n = 1'b1;
    ready_mode = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule